// File: doc/BRIEF.md
# Low-Power Mode Clock Gating Controller

This block sits between the software-visible power-mode bits of a small processor and the clock tree. It holds a four-bit mode word, turns it into one of six operating levels (one active level and five sleep levels of increasing depth), and drives registered enables for the CPU core, the main clock, the subsystem clock, the auxiliary clock, the oscillator DC generator and the crystal oscillator.

When an enabled interrupt is pending, the controller wakes the system to full activity so the handler can run. It saves the sleep word in a shadow register and clears the live word. When the handler returns, the live word is reloaded from the shadow and the system falls back to the level it was sleeping in. A separate input tells the block whether the DC generator feeds the clocks in active mode. This input decides how the second sleep level treats the generator.

Top module: `lpm_gate_top`

## Requirements
- R1: While reset is asserted and after it is released, the live mode word is 0000, the level is 0 (active), every enable output is 1 and the in-service flag is 0.
- R2: The mode word is bit0 cpuOff, bit1 oscOff, bit2 scg0, bit3 scg1. With cpuOff = 0 the level is 0 and all six enables are 1, whatever the other bits are.
- R3: Word 0001 (cpuOff only) gives level 1. CPU and main clock are off. Subsystem clock, auxiliary clock, DC generator and crystal are on.
- R4: Word 0101 (cpuOff, scg0) gives level 2. It matches level 1, except that the DC generator is on only when the dcoIsMclkSrc input is 1.
- R5: Word 1001 (cpuOff, scg1) gives level 3. CPU, main and subsystem clocks are off. Auxiliary clock, DC generator and crystal are on.
- R6: Word 1101 (cpuOff, scg0, scg1) gives level 4. It matches level 3, except that the DC generator is off.
- R7: Any word with cpuOff = 1 and oscOff = 1 gives level 5. All six enables are 0.
- R8: The enables, the level and the mode word change only on a rising clock edge. They reflect the inputs sampled at that edge one cycle later, and this includes the dcoIsMclkSrc input.
- R9: If irqPending is high while not in service, the next edge saves the live word to the shadow, clears the live word (level 0, all enables on) and sets the in-service flag.
- R10: If irqReturn is high while in service, the next edge reloads the live word from the shadow and clears the flag. If irqReturn is high while not in service, it has no effect.
- R11: If a mode write and a wake arrive in the same cycle, the wake wins. The system stays active, and the written word goes into the shadow so that it takes effect on return.
- R12: While in service, irqPending has no effect and a mode write changes only the live word. The shadow is still restored on return. A return and a write in the same cycle: the return wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeWrEn | input | 1 | Write strobe for the mode word |
| modeWrData | input | 4 | New mode word {scg1, scg0, oscOff, cpuOff} |
| dcoIsMclkSrc | input | 1 | 1 when the DC generator clocks the system in active mode |
| irqPending | input | 1 | An enabled interrupt is pending |
| irqReturn | input | 1 | Pulse when the handler returns |
| cpuEn | output | 1 | CPU core enable |
| mclkEn | output | 1 | Main clock enable |
| smclkEn | output | 1 | Subsystem clock enable |
| aclkEn | output | 1 | Auxiliary clock enable |
| dcGenEn | output | 1 | Oscillator DC generator enable |
| xtalEn | output | 1 | Crystal oscillator enable |
| modeLevel | output | 3 | Current level, 0 active, 1 to 5 sleep levels |
| modeBits | output | 4 | Current live mode word |
| inService | output | 1 | Interrupt wake in progress |

## Verification
The block has no tunable sizes, so the bench builds it with its fixed package constants: a four-bit mode word and a three-bit level. At that size, the bench can cover the whole space. It writes all sixteen mode words with the generator-source input at both values, and each outcome is compared on every cycle against a behavioural reference model. The short service sequence lets the bench reach the corner cases in the interrupt handling. These are a wake colliding with a write, a return colliding with a write, a return outside service, a nested wake request, and a change of the source input during sleep.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  localparam int MODE_W  = 4;
  localparam int LEVEL_W = 3;
  localparam int NUM_EN  = 6;

  typedef struct packed {
    logic scg1;
    logic scg0;
    logic oscOff;
    logic cpuOff;
  } modeBits_t;

  typedef enum logic [LEVEL_W-1:0] {
    LVL_ACTIVE = 3'd0,
    LVL_SLEEP0 = 3'd1,
    LVL_SLEEP1 = 3'd2,
    LVL_SLEEP2 = 3'd3,
    LVL_SLEEP3 = 3'd4,
    LVL_SLEEP4 = 3'd5
  } pwrLevel_e;

  typedef struct packed {
    logic cpu;
    logic mclk;
    logic smclk;
    logic aclk;
    logic dcGen;
    logic xtal;
  } clkEnables_t;

  typedef struct packed {
    logic enterIsr;
    logic leaveIsr;
    logic swWrite;
  } ctlStrobe_t;

  function automatic pwrLevel_e levelOf(modeBits_t m);
    pwrLevel_e lv;
    if (!m.cpuOff)      lv = LVL_ACTIVE;
    else if (m.oscOff)  lv = LVL_SLEEP4;
    else begin
      case ({m.scg1, m.scg0})
        2'b00:   lv = LVL_SLEEP0;
        2'b01:   lv = LVL_SLEEP1;
        2'b10:   lv = LVL_SLEEP2;
        default: lv = LVL_SLEEP3;
      endcase
    end
    return lv;
  endfunction

  function automatic clkEnables_t enablesOf(pwrLevel_e lv, logic dcoSel);
    clkEnables_t e;
    e = '1;
    case (lv)
      LVL_ACTIVE: e = '1;
      LVL_SLEEP0: begin e.cpu = 1'b0; e.mclk = 1'b0; end
      LVL_SLEEP1: begin e.cpu = 1'b0; e.mclk = 1'b0; e.dcGen = dcoSel; end
      LVL_SLEEP2: begin e.cpu = 1'b0; e.mclk = 1'b0; e.smclk = 1'b0; end
      LVL_SLEEP3: begin e.cpu = 1'b0; e.mclk = 1'b0; e.smclk = 1'b0; e.dcGen = 1'b0; end
      default:    e = '0;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeWrEn,
  input  logic       irqPending,
  input  logic       irqReturn,
  output ctlStrobe_t strobe,
  output logic       inService
);

  logic svcQ;

  // A wake outranks everything while idle; a return is only legal in service.
  always_comb begin
    strobe.enterIsr = irqPending && !svcQ;
    strobe.leaveIsr = irqReturn && svcQ;
    strobe.swWrite  = modeWrEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                svcQ <= 1'b0;
    else if (strobe.enterIsr) svcQ <= 1'b1;
    else if (strobe.leaveIsr) svcQ <= 1'b0;
  end

  assign inService = svcQ;

endmodule

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [MODE_W-1:0] wrData,
  input  logic              dcoSel,
  output modeBits_t         liveMode,
  output pwrLevel_e         level,
  output clkEnables_t       enables
);

  modeBits_t   liveQ, shadowQ, liveD, shadowD;
  pwrLevel_e   levelQ, levelD;
  clkEnables_t enQ, enD;

  always_comb begin
    liveD   = liveQ;
    shadowD = shadowQ;
    if (strobe.enterIsr) begin
      // A write in the wake cycle is the sleep request the handler must return to.
      shadowD = strobe.swWrite ? modeBits_t'(wrData) : liveQ;
      liveD   = '0;
    end else if (strobe.leaveIsr) begin
      liveD = shadowQ;
    end else if (strobe.swWrite) begin
      liveD = modeBits_t'(wrData);
    end
    levelD = levelOf(liveD);
    enD    = enablesOf(levelD, dcoSel);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveQ   <= '0;
      shadowQ <= '0;
      levelQ  <= LVL_ACTIVE;
      enQ     <= '1;
    end else begin
      liveQ   <= liveD;
      shadowQ <= shadowD;
      levelQ  <= levelD;
      enQ     <= enD;
    end
  end

  assign liveMode = liveQ;
  assign level    = levelQ;
  assign enables  = enQ;

endmodule

// File: rtl/lpm_gate_top.sv
module lpm_gate_top
  import lpm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeWrEn,
  input  logic [MODE_W-1:0]  modeWrData,
  input  logic               dcoIsMclkSrc,
  input  logic               irqPending,
  input  logic               irqReturn,
  output logic               cpuEn,
  output logic               mclkEn,
  output logic               smclkEn,
  output logic               aclkEn,
  output logic               dcGenEn,
  output logic               xtalEn,
  output logic [LEVEL_W-1:0] modeLevel,
  output logic [MODE_W-1:0]  modeBits,
  output logic               inService
);

  ctlStrobe_t  strobe;
  modeBits_t   liveMode;
  pwrLevel_e   level;
  clkEnables_t enables;

  lpm_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeWrEn   (modeWrEn),
    .irqPending (irqPending),
    .irqReturn  (irqReturn),
    .strobe     (strobe),
    .inService  (inService)
  );

  lpm_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (modeWrData),
    .dcoSel   (dcoIsMclkSrc),
    .liveMode (liveMode),
    .level    (level),
    .enables  (enables)
  );

  assign cpuEn     = enables.cpu;
  assign mclkEn    = enables.mclk;
  assign smclkEn   = enables.smclk;
  assign aclkEn    = enables.aclk;
  assign dcGenEn   = enables.dcGen;
  assign xtalEn    = enables.xtal;
  assign modeLevel = level;
  assign modeBits  = liveMode;

endmodule

// File: rtl/lpm_gate_chk.sv
module lpm_gate_chk (
  input logic       clk,
  input logic       rstN,
  input logic       modeWrEn,
  input logic       irqPending,
  input logic       irqReturn,
  input logic       cpuEn,
  input logic       mclkEn,
  input logic       aclkEn,
  input logic       dcGenEn,
  input logic       xtalEn,
  input logic [2:0] modeLevel,
  input logic [3:0] modeBits,
  input logic       inService
);

  a_r2_cpu_only_active: assert property (@(posedge clk) disable iff (!rstN)
    cpuEn |-> (modeLevel == 3'd0));

  a_r3_main_follows_cpu: assert property (@(posedge clk) disable iff (!rstN)
    !cpuEn |-> !mclkEn);

  a_r7_deepest_all_off: assert property (@(posedge clk) disable iff (!rstN)
    (modeLevel == 3'd5) |-> (!aclkEn && !xtalEn && !dcGenEn && !cpuEn));

  a_r9_wake_active: assert property (@(posedge clk) disable iff (!rstN)
    (irqPending && !inService) |=> (inService && cpuEn && mclkEn && modeBits == 4'd0));

  a_r10_return_clears: assert property (@(posedge clk) disable iff (!rstN)
    (irqReturn && inService) |=> !inService);

  a_r10_stray_return: assert property (@(posedge clk) disable iff (!rstN)
    (irqReturn && !inService && !irqPending && !modeWrEn) |=> ($stable(modeBits) && !inService));

  a_r12_nested_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (irqPending && inService && !irqReturn) |=> inService);

endmodule

bind lpm_gate_top lpm_gate_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .modeWrEn   (modeWrEn),
  .irqPending (irqPending),
  .irqReturn  (irqReturn),
  .cpuEn      (cpuEn),
  .mclkEn     (mclkEn),
  .aclkEn     (aclkEn),
  .dcGenEn    (dcGenEn),
  .xtalEn     (xtalEn),
  .modeLevel  (modeLevel),
  .modeBits   (modeBits),
  .inService  (inService)
);

// File: tb/tb_lpm_gate_top.sv
module tb_lpm_gate_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       modeWrEn = 1'b0;
  logic [3:0] modeWrData = 4'd0;
  logic       dcoIsMclkSrc = 1'b1;
  logic       irqPending = 1'b0;
  logic       irqReturn = 1'b0;
  logic       cpuEn, mclkEn, smclkEn, aclkEn, dcGenEn, xtalEn;
  logic [2:0] modeLevel;
  logic [3:0] modeBits;
  logic       inService;

  lpm_gate_top dut (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .dcoIsMclkSrc(dcoIsMclkSrc), .irqPending(irqPending), .irqReturn(irqReturn),
    .cpuEn(cpuEn), .mclkEn(mclkEn), .smclkEn(smclkEn), .aclkEn(aclkEn),
    .dcGenEn(dcGenEn), .xtalEn(xtalEn), .modeLevel(modeLevel),
    .modeBits(modeBits), .inService(inService)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  int    refLive = 0, refShadow = 0, refSvc = 0;
  int    refLevel = 0;
  int    refEn = 6'b111111;   // {cpu,mclk,smclk,aclk,dcGen,xtal}
  int    nCompared = 0, nBad = 0;
  int    cycles = 0;
  string curReq = "R1";
  bit    done = 0;

  function automatic int lvlFor(int m);
    if ((m & 1) == 0) return 0;
    if ((m & 2) != 0) return 5;
    if (m == 4'b0001 || m == 4'b0000) return 1;
    case ((m >> 2) & 3)
      0: return 1;
      1: return 2;
      2: return 3;
      default: return 4;
    endcase
  endfunction

  function automatic int ensFor(int lv, bit dco);
    case (lv)
      0: return 6'b111111;
      1: return 6'b001111;
      2: return dco ? 6'b001111 : 6'b001101;
      3: return 6'b000111;
      4: return 6'b000101;
      default: return 6'b000000;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      refLive = 0; refShadow = 0; refSvc = 0;
    end else if (irqPending && refSvc == 0) begin
      refShadow = modeWrEn ? int'(modeWrData) : refLive;
      refLive = 0; refSvc = 1;
    end else if (irqReturn && refSvc == 1) begin
      refLive = refShadow; refSvc = 0;
    end else if (modeWrEn) begin
      refLive = int'(modeWrData);
    end
    refLevel = lvlFor(refLive);
    refEn = ensFor(refLevel, dcoIsMclkSrc);
  end

  task automatic cmp(string what, int act, int exp);
    nCompared++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cmp("enables", int'({cpuEn, mclkEn, smclkEn, aclkEn, dcGenEn, xtalEn}), refEn);
      cmp("level", int'(modeLevel), refLevel);
      cmp("modeBits", int'(modeBits), refLive);
      cmp("inService", int'(inService), refSvc);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic writeMode(int m);
    modeWrEn = 1'b1; modeWrData = 4'(m);
    step(1);
    modeWrEn = 1'b0;
  endtask

  function automatic string tagFor(int m);
    case (lvlFor(m))
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    rstN = 1'b0;
    curReq = "R1";
    step(3);
    rstN = 1'b1;
    step(2);

    // all sixteen words at both generator-source settings: R2..R7
    for (int d = 0; d < 2; d++) begin
      dcoIsMclkSrc = d[0];
      for (int m = 0; m < 16; m++) begin
        curReq = tagFor(m);
        writeMode(m);
        step(2);
      end
    end

    // R8: source input flips while in level 2, enable follows one edge later
    curReq = "R8";
    dcoIsMclkSrc = 1'b1;
    writeMode(4'b0101);
    step(2);
    dcoIsMclkSrc = 1'b0;
    step(2);
    dcoIsMclkSrc = 1'b1;
    step(2);

    // R9/R10: wake from level 4 and return
    curReq = "R9";
    writeMode(4'b1101);
    step(1);
    irqPending = 1'b1; step(1); irqPending = 1'b0;
    step(3);
    curReq = "R10";
    irqReturn = 1'b1; step(1); irqReturn = 1'b0;
    step(2);
    // stray return outside service
    irqReturn = 1'b1; step(2); irqReturn = 1'b0;
    step(1);

    // R11: wake collides with write of deepest level
    curReq = "R11";
    writeMode(0);
    modeWrEn = 1'b1; modeWrData = 4'b0011; irqPending = 1'b1;
    step(1);
    modeWrEn = 1'b0; irqPending = 1'b0;
    step(2);
    irqReturn = 1'b1; step(1); irqReturn = 1'b0;
    step(2);

    // R12: nested wake ignored, write in service, return beats write
    curReq = "R12";
    writeMode(4'b1001);
    irqPending = 1'b1; step(1);
    step(2);                       // still pending while in service
    irqPending = 1'b0;
    writeMode(4'b0001);
    step(1);
    modeWrEn = 1'b1; modeWrData = 4'b0011; irqReturn = 1'b1;
    step(1);
    modeWrEn = 1'b0; irqReturn = 1'b0;
    step(3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nBad);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    if (!done) begin
      done = 1;
      nCompared++; nBad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 5000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nBad);
      $finish;
    end
  end

endmodule